// File: doc/BRIEF.md
# DMA Descriptor Submission Front End

This block is the software-facing control and status front end for a single-channel DMA engine. Software programs transfer parameters into staging registers over a simple 32-bit register bus: source and destination address, row length, row count, the two strides, and a cyclic mode flag. It then writes a commit strobe. Each commit copies the staged values into a small descriptor queue and gives the entry a rolling tag. Entries leave the queue in commit order through a valid/ready descriptor port to a downstream transfer engine.

The engine reports each finished descriptor by its tag. The block turns these reports into a per-tag done mask. It also raises two interrupt causes: one when a descriptor is handed off, which frees a queue slot, and one when a completion is accepted. Each cause has a mask bit and a write-one-to-clear pending bit.

The run bit stops the channel and empties the queue. The hold bit pauses handoff and keeps the queued entries.

Top module: `dma_submit_regs`

## Requirements
- R1: After reset the queue is empty and `descValid` is low. The next-tag register (0x004), the done mask (0x028), the pending register (0x044), the commit register (0x008), the control register (0x000) and the status register (0x030) all read 0. The mask register (0x040) reads 3, and `irq` is low.
- R2: Writing a value with bit 0 set to the commit register (0x008) while the run bit is 1 queues the staged parameters on the following clock. Entries appear on the descriptor port in commit order with the staged field values unchanged. The staged fields are source 0x010, destination 0x014, row length 0x018, row count 0x01C, source stride 0x020 and destination stride 0x024. The head entry stays stable while `descValid` is high and `descReady` is low.
- R3: The next-tag register (0x004) returns the tag that the next committed descriptor receives. This tag appears on `descTag` at that descriptor's handoff. Tags advance by one per commit, modulo 2^TAG_W.
- R4: The commit register reads 1 while a commit is waiting or the queue holds QDEPTH entries, and reads 0 otherwise. A commit written while the queue is full waits, without taking a tag, and is queued on the clock after a slot frees.
- R5: `descValid` is high only while control bit 0 (run) is 1, control bit 1 (hold) is 0 and the queue is not empty. Setting hold stops handoff without losing entries.
- R6: Writing the control register with bit 0 clear empties the queue by the next clock, cancels a waiting commit and clears the busy state. While run is 0, commit writes and completion reports are ignored: the tag, queue, done mask and pending bits do not change.
- R7: Done-mask bit n is set by a completion report carrying tag n while run is 1. It is cleared when tag n is given to a newly queued descriptor.
- R8: Pending bit 0 is set by each handoff and pending bit 1 by each accepted completion. Writing 1 to a pending bit clears it and writing 0 leaves it. A set in the same cycle as a clear wins.
- R9: The source register (0x048) equals pending AND NOT mask, where a mask bit of 1 suppresses that cause. `irq` is the OR of the source bits.
- R10: The active-tag register (0x02C) holds the tag of the most recent handoff. Status bit 0 is 1 while handed-off descriptors remain without a completion report.
- R11: Mode register (0x00C) bit 0 is captured at commit and travels with the descriptor as `descCyclic`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; data is returned on the next clock |
| regAddr | input | ADDR_W | Byte address of the register |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Registered read data |
| descValid | output | 1 | Head descriptor offered to the engine |
| descReady | input | 1 | Engine accepts the head descriptor |
| descSrcAddr | output | 32 | Source address of the head descriptor |
| descDstAddr | output | 32 | Destination address of the head descriptor |
| descXLen | output | 32 | Row length of the head descriptor |
| descYLen | output | 32 | Row count of the head descriptor |
| descSrcStride | output | 32 | Source stride of the head descriptor |
| descDstStride | output | 32 | Destination stride of the head descriptor |
| descCyclic | output | 1 | Cyclic mode flag of the head descriptor |
| descTag | output | TAG_W | Tag of the head descriptor |
| doneValid | input | 1 | Completion report strobe |
| doneTag | input | TAG_W | Tag of the finished descriptor |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with TAG_W = 2 and QDEPTH = 4, so the tag space and the queue are the same size. Four commits fill the queue, which exercises the full read-back and a commit that waits for a slot. A fifth commit reuses tag 0, which brings the tag wrap and the clearing of a stale done bit within reach of short directed sequences. Random interleavings of commits, handoffs, completions, mask writes and pending clears then run against a bench model of the queue, the tags and the interrupt state.

// File: rtl/dsub_pkg.sv
`timescale 1ns/1ps
package dsub_pkg;
  parameter int REG_W  = 32;
  parameter int ADDR_W = 12;

  // register offsets (byte addresses)
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_TAG    = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_SRC    = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_DST    = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_XLEN   = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_YLEN   = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_SSTR   = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_DSTR   = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_DONE   = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_ACTIVE = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_SRCIRQ = 12'h048;

  // interrupt cause bit positions
  localparam int IRQ_TAKEN    = 0;
  localparam int IRQ_FINISHED = 1;

  typedef struct packed {
    logic [REG_W-1:0] srcAddr;
    logic [REG_W-1:0] dstAddr;
    logic [REG_W-1:0] xLen;
    logic [REG_W-1:0] yLen;
    logic [REG_W-1:0] srcStride;
    logic [REG_W-1:0] dstStride;
    logic             cyclic;
  } desc_t;

  // control -> datapath strobes
  typedef struct packed {
    logic push;   // copy staging into the tail slot
    logic pop;    // head slot handed to the engine
    logic flush;  // drop all queued slots
    logic offer;  // head slot is being offered
  } strobe_t;

  // control state as read-back words
  typedef struct packed {
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] nextTag;
    logic [REG_W-1:0] commit;
    logic [REG_W-1:0] done;
    logic [REG_W-1:0] active;
    logic [REG_W-1:0] status;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] pend;
    logic [REG_W-1:0] source;
  } view_t;
endpackage

// File: rtl/dsub_ctrl.sv
`timescale 1ns/1ps
module dsub_ctrl
  import dsub_pkg::*;
#(
  parameter int TAG_W  = 2,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        regBits,
  input  logic              descReady,
  input  logic              doneValid,
  input  logic [TAG_W-1:0]  doneTag,
  output logic              descValid,
  output logic [TAG_W-1:0]  descTag,
  output strobe_t           strobe,
  output view_t             view,
  output logic              irq
);
  localparam int NTAG  = 1 << TAG_W;
  localparam int CNT_W = $clog2(QDEPTH + 1);
  localparam int OUT_W = CNT_W + TAG_W;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(QDEPTH);

  logic              runEn, holdEn, commitPend;
  logic [CNT_W-1:0]  count;
  logic [TAG_W-1:0]  nextTag, activeTag;
  logic [NTAG-1:0]   doneMask, doneNext;
  logic [OUT_W-1:0]  outCnt;
  logic [1:0]        pend, mask, pendSet, pendClr;

  logic wrCtrl, wrCommit, flush, full, push, pop, doneOk, outDec;

  assign wrCtrl   = regWr && (regAddr == OFS_CTRL);
  assign wrCommit = regWr && (regAddr == OFS_COMMIT) && regBits[0];
  assign flush    = wrCtrl && !regBits[0];
  assign full     = (count == CNT_FULL);
  assign push     = commitPend && runEn && !full;
  assign descValid = runEn && !holdEn && (count != '0);
  assign pop      = descValid && descReady;
  assign doneOk   = doneValid && runEn;
  assign outDec   = doneOk && (outCnt != '0);
  assign descTag  = nextTag - TAG_W'(count);

  assign strobe.push  = push;
  assign strobe.pop   = pop;
  assign strobe.flush = flush;
  assign strobe.offer = descValid;

  // control bits and commit request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn      <= 1'b0;
      holdEn     <= 1'b0;
      commitPend <= 1'b0;
    end else begin
      if (wrCtrl) begin
        runEn  <= regBits[0];
        holdEn <= regBits[1];
      end
      if (flush)                  commitPend <= 1'b0;
      else if (wrCommit && runEn) commitPend <= 1'b1;
      else if (push)              commitPend <= 1'b0;
    end
  end

  // occupancy and tag counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      nextTag <= '0;
    end else begin
      if (flush) count <= '0;
      else begin
        unique case ({push, pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
      if (push) nextTag <= nextTag + 1'b1;
    end
  end

  // per-tag done mask: reassignment clears, completion sets
  always_comb begin
    doneNext = doneMask;
    for (int t = 0; t < NTAG; t++) begin
      if (push && nextTag == TAG_W'(t))         doneNext[t] = 1'b0;
      else if (doneOk && doneTag == TAG_W'(t))  doneNext[t] = 1'b1;
    end
  end

  // outstanding handoffs and active tag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneMask  <= '0;
      outCnt    <= '0;
      activeTag <= '0;
    end else begin
      doneMask <= doneNext;
      if (flush)                outCnt <= '0;
      else if (pop && !outDec)  outCnt <= outCnt + 1'b1;
      else if (!pop && outDec)  outCnt <= outCnt - 1'b1;
      if (pop) activeTag <= descTag;
    end
  end

  // interrupt causes
  always_comb begin
    pendSet = '0;
    pendSet[IRQ_TAKEN]    = pop;
    pendSet[IRQ_FINISHED] = doneOk;
    pendClr = (regWr && regAddr == OFS_PEND) ? regBits : 2'b00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
      mask <= 2'b11;
    end else begin
      pend <= pendSet | (pend & ~pendClr);
      if (regWr && regAddr == OFS_MASK) mask <= regBits;
    end
  end

  assign irq = |(pend & ~mask);

  always_comb begin
    view.ctrl    = REG_W'({holdEn, runEn});
    view.nextTag = REG_W'(nextTag);
    view.commit  = REG_W'(commitPend || full);
    view.done    = REG_W'(doneMask);
    view.active  = REG_W'(activeTag);
    view.status  = REG_W'(outCnt != '0);
    view.mask    = REG_W'(mask);
    view.pend    = REG_W'(pend);
    view.source  = REG_W'(pend & ~mask);
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_FULL);

  assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0 && !descValid));

  assert_ignore_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !runEn) |=> $stable(doneMask));

  assert_tag_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    push |=> (nextTag == $past(nextTag) + 1'b1));

  assert_done_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    push |=> !doneMask[$past(nextTag)]);

  assert_taken_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    pop |=> pend[IRQ_TAKEN]);
endmodule

// File: rtl/dsub_data.sv
`timescale 1ns/1ps
module dsub_data
  import dsub_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWData,
  input  strobe_t           strobe,
  input  view_t             view,
  output desc_t             descOut,
  output logic [REG_W-1:0]  regRData
);
  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(QDEPTH - 1);

  desc_t            stage;
  desc_t            slot [QDEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [REG_W-1:0] rdMux;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  // staging registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
    end else if (regWr) begin
      unique case (regAddr)
        OFS_SRC:  stage.srcAddr   <= regWData;
        OFS_DST:  stage.dstAddr   <= regWData;
        OFS_XLEN: stage.xLen      <= regWData;
        OFS_YLEN: stage.yLen      <= regWData;
        OFS_SSTR: stage.srcStride <= regWData;
        OFS_DSTR: stage.dstStride <= regWData;
        OFS_MODE: stage.cyclic    <= regWData[0];
        default:  ;
      endcase
    end
  end

  // queue slots
  for (genvar s = 0; s < QDEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.push && wrPtr == PTR_W'(s)) slot[s] <= stage;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
    end
  end

  assign descOut = slot[rdPtr];

  // read-back
  always_comb begin
    unique case (regAddr)
      OFS_CTRL:   rdMux = view.ctrl;
      OFS_TAG:    rdMux = view.nextTag;
      OFS_COMMIT: rdMux = view.commit;
      OFS_MODE:   rdMux = REG_W'(stage.cyclic);
      OFS_SRC:    rdMux = stage.srcAddr;
      OFS_DST:    rdMux = stage.dstAddr;
      OFS_XLEN:   rdMux = stage.xLen;
      OFS_YLEN:   rdMux = stage.yLen;
      OFS_SSTR:   rdMux = stage.srcStride;
      OFS_DSTR:   rdMux = stage.dstStride;
      OFS_DONE:   rdMux = view.done;
      OFS_ACTIVE: rdMux = view.active;
      OFS_STATUS: rdMux = view.status;
      OFS_MASK:   rdMux = view.mask;
      OFS_PEND:   rdMux = view.pend;
      OFS_SRCIRQ: rdMux = view.source;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      regRData <= '0;
    else if (regRd) regRData <= rdMux;
  end

  assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.offer && !strobe.pop) |=> (!strobe.offer || $stable(descOut)));
endmodule

// File: rtl/dma_submit_regs.sv
`timescale 1ns/1ps
module dma_submit_regs
  import dsub_pkg::*;
#(
  parameter int TAG_W  = 2,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWData,
  output logic [REG_W-1:0]  regRData,
  output logic              descValid,
  input  logic              descReady,
  output logic [REG_W-1:0]  descSrcAddr,
  output logic [REG_W-1:0]  descDstAddr,
  output logic [REG_W-1:0]  descXLen,
  output logic [REG_W-1:0]  descYLen,
  output logic [REG_W-1:0]  descSrcStride,
  output logic [REG_W-1:0]  descDstStride,
  output logic              descCyclic,
  output logic [TAG_W-1:0]  descTag,
  input  logic              doneValid,
  input  logic [TAG_W-1:0]  doneTag,
  output logic              irq
);
  strobe_t strobe;
  view_t   view;
  desc_t   descOut;

  dsub_ctrl #(.TAG_W(TAG_W), .QDEPTH(QDEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regBits   (regWData[1:0]),
    .descReady (descReady),
    .doneValid (doneValid),
    .doneTag   (doneTag),
    .descValid (descValid),
    .descTag   (descTag),
    .strobe    (strobe),
    .view      (view),
    .irq       (irq)
  );

  dsub_data #(.QDEPTH(QDEPTH)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regRd    (regRd),
    .regAddr  (regAddr),
    .regWData (regWData),
    .strobe   (strobe),
    .view     (view),
    .descOut  (descOut),
    .regRData (regRData)
  );

  assign descSrcAddr   = descOut.srcAddr;
  assign descDstAddr   = descOut.dstAddr;
  assign descXLen      = descOut.xLen;
  assign descYLen      = descOut.yLen;
  assign descSrcStride = descOut.srcStride;
  assign descDstStride = descOut.dstStride;
  assign descCyclic    = descOut.cyclic;
endmodule

// File: tb/dma_submit_regs_test.sv
`timescale 1ns/1ps
module dma_submit_regs_test;
  import dsub_pkg::*;
  localparam int TAG_W  = 2;
  localparam int QDEPTH = 4;
  localparam int NTAG   = 1 << TAG_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWData = '0, regRData;
  logic descValid, descReady = 1'b0, descCyclic;
  logic [31:0] descSrcAddr, descDstAddr, descXLen, descYLen, descSrcStride, descDstStride;
  logic [TAG_W-1:0] descTag, doneTag = '0;
  logic doneValid = 1'b0, irq;

  always #2 clk = ~clk;

  dma_submit_regs #(.TAG_W(TAG_W), .QDEPTH(QDEPTH)) uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .descValid(descValid), .descReady(descReady),
    .descSrcAddr(descSrcAddr), .descDstAddr(descDstAddr), .descXLen(descXLen),
    .descYLen(descYLen), .descSrcStride(descSrcStride), .descDstStride(descDstStride),
    .descCyclic(descCyclic), .descTag(descTag), .doneValid(doneValid), .doneTag(doneTag),
    .irq(irq)
  );

  typedef struct {
    logic [31:0] s, d, x, y, ss, ds;
    logic        c;
    int          tag;
  } bd_t;

  int nChk = 0, nBad = 0;
  bd_t eq [16];
  int qH = 0, qN = 0;
  int oT [64];
  int oH = 0, oN = 0;
  int mTag = 0, mActive = 0;
  logic [NTAG-1:0] mDone = '0;
  logic [1:0] mPend = 2'b00, mMask = 2'b11;
  bit run = 0;

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] v);
    regWr = 1'b1; regAddr = a; regWData = v;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdChk(input string req, input string what, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    check(req, what, regRData, exp);
  endtask

  function automatic bd_t randDesc();
    bd_t d;
    d.s = $urandom; d.d = $urandom; d.x = $urandom; d.y = $urandom;
    d.ss = $urandom; d.ds = $urandom; d.c = 1'($urandom % 2); d.tag = 0;
    return d;
  endfunction

  task automatic stageDesc(input bd_t d);
    wr(OFS_SRC, d.s);   wr(OFS_DST, d.d);   wr(OFS_XLEN, d.x);
    wr(OFS_YLEN, d.y);  wr(OFS_SSTR, d.ss); wr(OFS_DSTR, d.ds);
    wr(OFS_MODE, {31'b0, d.c});
  endtask

  task automatic modelPush(input bd_t d);
    bd_t e = d;
    e.tag = mTag;
    eq[(qH + qN) % 16] = e;
    qN++;
    mDone[mTag] = 1'b0;
    mTag = (mTag + 1) % NTAG;
  endtask

  task automatic commitOne(input bd_t d);
    rdChk("R3", "next tag before commit", OFS_TAG, mTag);
    stageDesc(d);
    wr(OFS_COMMIT, 32'd1);
    @(negedge clk);
    modelPush(d);
  endtask

  task automatic takeOne(input bit pendClr);
    bd_t h = eq[qH];
    check("R5", "valid offered", {31'b0, descValid}, 32'd1);
    check("R2", "src addr", descSrcAddr, h.s);
    check("R2", "dst addr", descDstAddr, h.d);
    check("R2", "row length", descXLen, h.x);
    check("R2", "row count", descYLen, h.y);
    check("R2", "src stride", descSrcStride, h.ss);
    check("R2", "dst stride", descDstStride, h.ds);
    check("R11", "cyclic flag", {31'b0, descCyclic}, {31'b0, h.c});
    check("R3", "handoff tag", {30'b0, descTag}, h.tag);
    descReady = 1'b1;
    if (pendClr) begin regWr = 1'b1; regAddr = OFS_PEND; regWData = 32'd1; end
    @(negedge clk);
    descReady = 1'b0; regWr = 1'b0;
    qH = (qH + 1) % 16; qN--;
    mPend[IRQ_TAKEN] = 1'b1;
    mActive = h.tag;
    oT[(oH + oN) % 64] = h.tag; oN++;
  endtask

  task automatic completeTag(input int t);
    doneValid = 1'b1; doneTag = TAG_W'(t);
    @(negedge clk);
    doneValid = 1'b0;
    if (run) begin mDone[t] = 1'b1; mPend[IRQ_FINISHED] = 1'b1; end
  endtask

  task automatic completeOne();
    int t = oT[oH];
    oH = (oH + 1) % 64; oN--;
    completeTag(t);
  endtask

  task automatic checkRegs();
    rdChk("R7", "done mask", OFS_DONE, {28'b0, mDone});
    rdChk("R8", "pending", OFS_PEND, {30'b0, mPend});
    rdChk("R9", "irq source", OFS_SRCIRQ, {30'b0, mPend & ~mMask});
    check("R9", "irq line", {31'b0, irq}, {31'b0, |(mPend & ~mMask)});
    rdChk("R10", "busy", OFS_STATUS, (oN != 0) ? 32'd1 : 32'd0);
    rdChk("R10", "active tag", OFS_ACTIVE, mActive);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int unsigned seedVal;
    bd_t d5;
    seedVal = $urandom(32'd20250611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "valid after reset", {31'b0, descValid}, 32'd0);
    check("R1", "irq after reset", {31'b0, irq}, 32'd0);
    rdChk("R1", "control", OFS_CTRL, 32'd0);
    rdChk("R1", "next tag", OFS_TAG, 32'd0);
    rdChk("R1", "done mask", OFS_DONE, 32'd0);
    rdChk("R1", "mask", OFS_MASK, 32'd3);
    rdChk("R1", "pending", OFS_PEND, 32'd0);
    rdChk("R1", "commit busy", OFS_COMMIT, 32'd0);
    rdChk("R1", "status", OFS_STATUS, 32'd0);

    wr(OFS_CTRL, 32'd1); run = 1;
    wr(OFS_MASK, 32'd0); mMask = 2'b00;

    // R4: fill the queue, then a commit that has to wait
    for (int i = 0; i < QDEPTH; i++) commitOne(randDesc());
    rdChk("R4", "commit reads busy when full", OFS_COMMIT, 32'd1);
    d5 = randDesc();
    stageDesc(d5);
    wr(OFS_COMMIT, 32'd1);
    repeat (2) @(negedge clk);
    rdChk("R4", "commit still waiting", OFS_COMMIT, 32'd1);
    rdChk("R4", "no tag taken while waiting", OFS_TAG, mTag);
    takeOne(0);
    @(negedge clk);
    modelPush(d5);
    rdChk("R3", "tag wrapped after waiting commit", OFS_TAG, mTag);
    while (qN > 0) takeOne(0);
    rdChk("R4", "commit reads idle", OFS_COMMIT, 32'd0);
    while (oN > 0) completeOne();
    checkRegs();

    // R5 hold keeps the entry
    commitOne(randDesc());
    wr(OFS_CTRL, 32'd3);
    @(negedge clk);
    check("R5", "no offer while held", {31'b0, descValid}, 32'd0);
    wr(OFS_CTRL, 32'd1);
    check("R5", "offer after release", {31'b0, descValid}, 32'd1);
    takeOne(0);

    // R8 set wins over a same-cycle clear
    wr(OFS_PEND, 32'd3); mPend = 2'b00;
    commitOne(randDesc());
    takeOne(1);
    checkRegs();
    wr(OFS_PEND, 32'd2); mPend[IRQ_FINISHED] = 1'b0;
    checkRegs();
    while (oN > 0) completeOne();
    checkRegs();

    // mixed random traffic
    for (int it = 0; it < 80; it++) begin
      int op = int'($urandom % 6);
      case (op)
        0, 1: if (qN < QDEPTH) commitOne(randDesc());
        2:    if (qN > 0) takeOne(0);
        3:    if (oN > 0) completeOne();
        4: begin
          logic [1:0] v = 2'($urandom % 4);
          wr(OFS_PEND, {30'b0, v}); mPend = mPend & ~v;
        end
        default: begin
          logic [1:0] v = 2'($urandom % 4);
          wr(OFS_MASK, {30'b0, v}); mMask = v;
        end
      endcase
      checkRegs();
    end

    // R6 disable flushes queue, waiting commit and busy state
    while (qN > 0) takeOne(0);
    while (oN > 0) completeOne();
    commitOne(randDesc());
    takeOne(0);
    for (int i = 0; i < QDEPTH; i++) commitOne(randDesc());
    wr(OFS_COMMIT, 32'd1);
    wr(OFS_CTRL, 32'd0); run = 0; qN = 0; oN = 0;
    check("R6", "no offer after disable", {31'b0, descValid}, 32'd0);
    rdChk("R6", "busy cleared", OFS_STATUS, 32'd0);
    completeTag(mActive);
    checkRegs();
    wr(OFS_COMMIT, 32'd1);
    wr(OFS_CTRL, 32'd1); run = 1;
    repeat (2) @(negedge clk);
    check("R6", "queue empty after re-enable", {31'b0, descValid}, 32'd0);
    rdChk("R6", "tag unchanged by ignored commits", OFS_TAG, mTag);
    rdChk("R6", "no commit waiting", OFS_COMMIT, 32'd0);
    checkRegs();

    summary();
    $finish;
  end
endmodule